// File: doc/BRIEF.md
# Token-Driven Multiplexer Select Decoder

This block stands in front of one input multiplexer of a reconfigurable processing array, either at a functional-unit operand input or at a register-file write port. No source-select field for that multiplexer is kept in configuration memory. Each candidate producer instead drives a one-bit token wire toward this multiplexer in the cycle before its data arrives. The decoder watches all of those wires and derives the multiplexer select from the position of the wire that carries a token.

The select is registered, so a token seen in one cycle sets up the multiplexer for the data that arrives in the following cycle. A valid flag tells the datapath whether anything arrives at all. When no token is seen, the valid flag is low and the select keeps its previous value, so the multiplexer control does not toggle. When two or more tokens arrive together, the decoder raises an error flag and still picks the lowest position. Each producer also sends a staging-predicate bit with its token, and the decoder passes on the bit that belongs to the selected producer.

Top module: `tokenSelectDecoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, selOut, selValid, collisionErr and stagePredOut are all 0.
- R2: If exactly one bit tokenIn[i] is high at a rising edge, then after that edge selValid is 1 and selOut equals i as an unsigned binary number. The latency is one cycle.
- R3: If tokenIn is all zero at a rising edge, then after that edge selValid is 0 and selOut keeps the value it had before that edge.
- R4: If two or more tokenIn bits are high at a rising edge, then after that edge collisionErr is 1, selValid is 1, and selOut equals the lowest index among the high bits.
- R5: If zero or one tokenIn bits are high at a rising edge, then after that edge collisionErr is 0.
- R6: After an edge that saw at least one token, stagePredOut equals stagePredIn[k] as sampled at that edge, where k is the selected index. After an edge that saw no token, stagePredOut is 0.
- R7: Predicate bits at positions other than the selected one have no effect on stagePredOut or selOut.
- R8: selOut is max(1, ceil(log2 N)) bits wide, and every position from 0 to N-1 can be selected, including the highest, N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| tokenIn | input | N | One token wire from each candidate producer |
| stagePredIn | input | N | Staging-predicate bit sent with each token |
| selOut | output | SEL_W | Registered binary select for the datapath multiplexer |
| selValid | output | 1 | High when data arrives at the multiplexer in this cycle |
| collisionErr | output | 1 | High when the last sampled cycle carried several tokens |
| stagePredOut | output | 1 | Staging predicate of the selected producer |

## Verification
A walking single token through all N positions, including the highest, shows that every index is encoded correctly and that the latency is one cycle. Cycles with no token placed between distinct selects show the difference between holding the select and clearing it. Pairs and dense patterns show whether the lowest position wins over higher ones and whether the error flag stays apart from the single-token case. Predicate bits that are set only at positions that were not selected show whether the forwarded predicate comes from the correct position. Random mixes with a fixed seed cover the sparse, single and crowded cases in arbitrary orders.

// File: rtl/tokSelPkg.sv
package tokSelPkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic load;       // a token was seen: capture the new select and predicate
    logic clearPred;  // no token was seen: drive the forwarded predicate low
  } selStrobeT;
endpackage

// File: rtl/tokSelCtrl.sv
module tokSelCtrl
  import tokSelPkg::*;
#(
  parameter int N = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [N-1:0]    tokenIn,
  output selStrobeT       strobe,
  output logic            selValid,
  output logic            collisionErr
);
  // seenBelow[i] is high when any token sits at a position lower than i
  logic [N-1:0] seenBelow;
  logic [N-1:0] clashBits;

  assign seenBelow[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_below
    assign seenBelow[i] = seenBelow[i-1] | tokenIn[i-1];
  end

  assign clashBits = tokenIn & seenBelow;

  logic anyTok;
  logic multiTok;
  assign anyTok   = |tokenIn;
  assign multiTok = |clashBits;

  always_comb begin
    strobe.load      = anyTok;
    strobe.clearPred = ~anyTok;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selValid     <= 1'b0;
      collisionErr <= 1'b0;
    end else begin
      selValid     <= anyTok;
      collisionErr <= multiTok;
    end
  end
endmodule

// File: rtl/tokSelPath.sv
module tokSelPath
  import tokSelPkg::*;
#(
  parameter int N     = 6,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     tokenIn,
  input  logic [N-1:0]     stagePredIn,
  input  selStrobeT        strobe,
  output logic [SEL_W-1:0] selOut,
  output logic             stagePredOut
);
  // Find the lowest set token: firstHot is one-hot or all zero
  logic [N-1:0] lowerAny;
  logic [N-1:0] firstHot;

  assign lowerAny[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_prefix
    assign lowerAny[i] = lowerAny[i-1] | tokenIn[i-1];
  end
  for (genvar i = 0; i < N; i++) begin : g_first
    assign firstHot[i] = tokenIn[i] & ~lowerAny[i];
  end

  logic [SEL_W-1:0] nextSel;
  logic             nextPred;

  always_comb begin
    nextSel = '0;
    for (int i = 0; i < N; i++) begin
      if (firstHot[i]) nextSel = nextSel | SEL_W'(i);
    end
    nextPred = |(firstHot & stagePredIn);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selOut       <= '0;
      stagePredOut <= 1'b0;
    end else begin
      if (strobe.load) selOut <= nextSel;
      if (strobe.clearPred)  stagePredOut <= 1'b0;
      else if (strobe.load)  stagePredOut <= nextPred;
    end
  end
endmodule

// File: rtl/tokenSelectDecoder.sv
module tokenSelectDecoder
  import tokSelPkg::*;
#(
  parameter int N = 6,
  localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     tokenIn,
  input  logic [N-1:0]     stagePredIn,
  output logic [SEL_W-1:0] selOut,
  output logic             selValid,
  output logic             collisionErr,
  output logic             stagePredOut
);
  selStrobeT strobe;

  tokSelCtrl #(.N(N)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .tokenIn      (tokenIn),
    .strobe       (strobe),
    .selValid     (selValid),
    .collisionErr (collisionErr)
  );

  tokSelPath #(.N(N), .SEL_W(SEL_W)) path_i (
    .clk          (clk),
    .rstN         (rstN),
    .tokenIn      (tokenIn),
    .stagePredIn  (stagePredIn),
    .strobe       (strobe),
    .selOut       (selOut),
    .stagePredOut (stagePredOut)
  );
endmodule

// File: rtl/tokSelChecker.sv
module tokSelChecker #(
  parameter int N     = 6,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [N-1:0]     tokenIn,
  input logic [N-1:0]     stagePredIn,
  input logic [SEL_W-1:0] selOut,
  input logic             selValid,
  input logic             collisionErr,
  input logic             stagePredOut
);
  // Tokens and predicates captured at the previous edge
  logic [N-1:0] prevTok;
  logic [N-1:0] prevPred;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevTok  <= '0;
      prevPred <= '0;
    end else begin
      prevTok  <= tokenIn;
      prevPred <= stagePredIn;
    end
  end

  logic [N-1:0] belowSel;
  always_comb begin
    belowSel = '0;
    for (int i = 0; i < N; i++) begin
      if (i < int'(selOut)) belowSel[i] = 1'b1;
    end
  end

  assert_valid_next_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|tokenIn) |=> selValid);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tokenIn == '0) |=> (!selValid && $stable(selOut)));

  assert_collide_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(tokenIn) > 1) |=> collisionErr);

  assert_no_collide_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(tokenIn) <= 1) |=> !collisionErr);

  assert_lowest_pick_R4: assert property (@(posedge clk) disable iff (!rstN)
    selValid |-> (prevTok[selOut] && ((prevTok & belowSel) == '0)));

  assert_pred_fwd_R6: assert property (@(posedge clk) disable iff (!rstN)
    selValid |-> (stagePredOut == prevPred[selOut]));

  assert_pred_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    !selValid |-> !stagePredOut);
endmodule

bind tokenSelectDecoder tokSelChecker #(.N(N), .SEL_W(SEL_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .tokenIn      (tokenIn),
  .stagePredIn  (stagePredIn),
  .selOut       (selOut),
  .selValid     (selValid),
  .collisionErr (collisionErr),
  .stagePredOut (stagePredOut)
);

// File: tb/tokenSelectDecoder_tb_top.sv
`timescale 1ns/1ps
module tokenSelectDecoder_tb_top;
  localparam int N     = 6;
  localparam int SEL_W = (N > 1) ? $clog2(N) : 1;

  logic             clk = 1'b0;
  logic             rstN;
  logic [N-1:0]     tokenIn;
  logic [N-1:0]     stagePredIn;
  logic [SEL_W-1:0] selOut;
  logic             selValid;
  logic             collisionErr;
  logic             stagePredOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [SEL_W-1:0] expSel = '0;

  always #5 clk = ~clk;

  tokenSelectDecoder #(.N(N)) dut_i (
    .clk(clk), .rstN(rstN), .tokenIn(tokenIn), .stagePredIn(stagePredIn),
    .selOut(selOut), .selValid(selValid), .collisionErr(collisionErr),
    .stagePredOut(stagePredOut)
  );

  function automatic int lowestIdx(logic [N-1:0] t);
    for (int i = 0; i < N; i++) if (t[i]) return i;
    return -1;
  endfunction

  function automatic int popCount(logic [N-1:0] t);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(t[i]);
    return c;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Apply one cycle of stimulus, then check every output after the edge
  task automatic cycleCheck(logic [N-1:0] tok, logic [N-1:0] pred);
    int lo;
    @(negedge clk);
    tokenIn = tok;
    stagePredIn = pred;
    @(posedge clk);
    #2;
    lo = lowestIdx(tok);
    if (lo >= 0) begin
      expSel = SEL_W'(lo);
      check("R2", "selValid", int'(selValid), 1);
      if (popCount(tok) > 1) begin
        check("R4", "selOut", int'(selOut), lo);
        check("R4", "collisionErr", int'(collisionErr), 1);
      end else begin
        check("R2", "selOut", int'(selOut), lo);
        check("R5", "collisionErr", int'(collisionErr), 0);
      end
      check("R6", "stagePredOut", int'(stagePredOut), int'(pred[lo]));
    end else begin
      check("R3", "selValid", int'(selValid), 0);
      check("R3", "selOut held", int'(selOut), int'(expSel));
      check("R5", "collisionErr", int'(collisionErr), 0);
      check("R6", "stagePredOut cleared", int'(stagePredOut), 0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    rstN = 1'b0;
    tokenIn = '0;
    stagePredIn = '1;
    repeat (3) @(posedge clk);
    #2;
    check("R1", "selOut in reset", int'(selOut), 0);
    check("R1", "selValid in reset", int'(selValid), 0);
    check("R1", "collisionErr in reset", int'(collisionErr), 0);
    check("R1", "stagePredOut in reset", int'(stagePredOut), 0);
    tokenIn = '1;
    @(negedge clk);
    rstN = 1'b1;
    tokenIn = '0;
    @(posedge clk);
    #2;
    check("R1", "selValid after reset", int'(selValid), 0);
    check("R1", "selOut after reset", int'(selOut), 0);

    // R2/R8: walk a single token across every position, highest included
    for (int i = 0; i < N; i++) cycleCheck(N'(1) << i, '0);
    check("R8", "selOut width", $bits(selOut), SEL_W);
    cycleCheck(N'(1) << (N-1), N'(1) << (N-1));
    check("R8", "top index selected", int'(selOut), N-1);

    // R3: idle cycles keep a nonzero select
    cycleCheck(N'(1) << 3, '0);
    cycleCheck('0, '1);
    cycleCheck('0, '0);

    // R4: lowest position wins among several tokens
    cycleCheck(N'(6'b101000), '0);
    cycleCheck('1, '0);
    cycleCheck(N'(6'b110000), '0);

    // R6/R7: predicate only from the chosen position
    cycleCheck(N'(6'b000100), N'(6'b111011));
    check("R7", "other predicates ignored", int'(stagePredOut), 0);
    cycleCheck(N'(6'b010010), N'(6'b010000));
    check("R7", "higher token predicate ignored", int'(stagePredOut), 0);
    check("R7", "select unaffected", int'(selOut), 1);
    cycleCheck(N'(6'b000100), N'(6'b000100));

    // Random mix of idle, single and crowded patterns
    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] t;
      logic [N-1:0] p;
      int kind;
      kind = int'($urandom % 4);
      p = N'($urandom);
      if (kind == 0) t = '0;
      else if (kind == 1) t = N'(1) << ($urandom % N);
      else t = N'($urandom);
      cycleCheck(t, p);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule